// File: doc/BRIEF.md
# Sequential Column-Scan Row Packetizer

This block sits behind a row arbiter in an event-driven pixel array readout. When the upstream side grants a row, the block captures that row's address and its column request vector in one cycle. It then puts the address on a shared output bus, followed by the row's whole fired/not-fired bitmap, cut into fixed-width packets. No per-column arbitration takes place: every column is reported in every row, whether or not it fired.

The time to send a row therefore does not depend on its contents. A row with no fired pixel takes the same number of beats as a row where every pixel fired. After the last packet, the block pulses an acknowledge to exactly those pixels it reported as fired, so they can reset. Only then does it accept the next row.

Top module: `colscan_packetizer`

## Requirements
- R1: `grant_ready` is high only while the block holds no row. While it is high, `row_strobe`, `pkt_strobe` and `row_done` are all low.
- R2: The cycle after a handshake (`grant_valid` and `grant_ready` both high at a rising edge) is the address beat. In that beat `row_strobe` is high and `bus_data` carries the captured row address, zero-extended. In any cycle with no strobe, `bus_data` is zero.
- R3: After the address beat come exactly NCOL/PKT_W packet beats on consecutive cycles, each marked by `pkt_strobe`. Reassembling them yields the captured request vector.
- R4: Packet k carries columns k*PKT_W up to k*PKT_W+PKT_W-1, with the lowest column in bit 0 of `bus_data`. Packets go out from k=0 upward. A 1 bit means the pixel has fired; a 0 bit means it has not.
- R5: Changes on `col_req` after the handshake have no effect on the packets or on the acknowledge of that row.
- R6: The cycle after the last packet, `row_done` is high for one cycle and `pix_ack` equals the captured request vector. Outside that cycle, `pix_ack` is zero.
- R7: Every row occupies exactly NCOL/PKT_W+2 consecutive output cycles (address beat, packets, done), with no gap. This holds for every bitmap, including all zeros and all ones. At most one of the three strobes is high at a time.
- R8: A new row is accepted only after `row_done` of the previous row. A `grant_valid` held during a row is not taken until the cycle after `row_done`, when `grant_ready` returns high.
- R9: After reset, `grant_ready` is high, all strobes are low, and `bus_data` and `pix_ack` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_valid | input | 1 | Upstream offers a granted row |
| grant_row | input | ROW_AW | Address of the offered row |
| col_req | input | NCOL | Column request vector of the offered row (1 = fired) |
| grant_ready | output | 1 | Block is idle and takes the offered row |
| bus_data | output | max(ROW_AW,PKT_W) | Row address on the address beat, packet on packet beats, else zero |
| row_strobe | output | 1 | Address beat marker |
| pkt_strobe | output | 1 | Packet beat marker |
| row_done | output | 1 | End of row; acknowledge is valid |
| pix_ack | output | NCOL | Acknowledge to the fired pixels of the captured row |

## Verification
A wrong beat counter shows at the ports within one row. The done pulse arrives early or late relative to the address beat, the row length differs from NCOL/PKT_W+2, or a reassembled bitmap comes out with lost or repeated packets. A shift register that misses its load or its shift is caught at the first wrong packet, because the bench compares every packet against the vector driven at the handshake. That vector is then inverted on the input, which exposes any late sampling within the same row. A state that lets a grant in early shows up as a second address beat before `row_done`.

// File: rtl/colscan_pkg.sv
package colscan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_PKT  = 2'd2,
        ST_DONE = 2'd3
    } scan_state_e;

endpackage

// File: rtl/colscan_ctrl.sv
module colscan_ctrl
    import colscan_pkg::*;
#(
    parameter int NPKT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_valid,
    output logic grant_ready,
    output logic load,
    output logic in_addr,
    output logic in_pkt,
    output logic in_done
);
    localparam int CW = (NPKT > 1) ? $clog2(NPKT) : 1;

    typedef struct packed {
        scan_state_e     state;
        logic [CW-1:0]   beat;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (grant_valid) begin
                    ctrl_d.state = ST_ADDR;
                    ctrl_d.beat  = '0;
                end
            end
            ST_ADDR: ctrl_d.state = ST_PKT;
            ST_PKT: begin
                if (ctrl_q.beat == CW'(NPKT - 1)) begin
                    ctrl_d.state = ST_DONE;
                    ctrl_d.beat  = '0;
                end else begin
                    ctrl_d.beat = ctrl_q.beat + 1'b1;
                end
            end
            ST_DONE: ctrl_d.state = ST_IDLE;
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, beat: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign grant_ready = (ctrl_q.state == ST_IDLE);
    assign load        = grant_ready && grant_valid;
    assign in_addr     = (ctrl_q.state == ST_ADDR);
    assign in_pkt      = (ctrl_q.state == ST_PKT);
    assign in_done     = (ctrl_q.state == ST_DONE);

endmodule

// File: rtl/colscan_shift.sv
module colscan_shift #(
    parameter int NCOL   = 16,
    parameter int PKT_W  = 4,
    parameter int ROW_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ROW_AW-1:0] grant_row,
    input  logic [NCOL-1:0]   col_req,
    output logic [ROW_AW-1:0] row_addr,
    output logic [PKT_W-1:0]  pkt_bits,
    output logic [NCOL-1:0]   bitmap
);
    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [NCOL-1:0]   keep;
        logic [NCOL-1:0]   shift;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.row   = grant_row;
            hold_d.keep  = col_req;
            hold_d.shift = col_req;
        end else if (advance) begin
            hold_d.shift = hold_q.shift >> PKT_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign row_addr = hold_q.row;
    assign pkt_bits = hold_q.shift[PKT_W-1:0];
    assign bitmap   = hold_q.keep;

endmodule

// File: rtl/colscan_packetizer.sv
module colscan_packetizer #(
    parameter int NCOL   = 16,
    parameter int PKT_W  = 4,
    parameter int ROW_AW = 5
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  grant_valid,
    input  logic [ROW_AW-1:0]                                     grant_row,
    input  logic [NCOL-1:0]                                       col_req,
    output logic                                                  grant_ready,
    output logic [((ROW_AW > PKT_W) ? ROW_AW : PKT_W)-1:0]        bus_data,
    output logic                                                  row_strobe,
    output logic                                                  pkt_strobe,
    output logic                                                  row_done,
    output logic [NCOL-1:0]                                       pix_ack
);
    localparam int NPKT  = NCOL / PKT_W;
    localparam int BUS_W = (ROW_AW > PKT_W) ? ROW_AW : PKT_W;

    logic              load;
    logic              in_addr;
    logic              in_pkt;
    logic              in_done;
    logic [ROW_AW-1:0] row_addr;
    logic [PKT_W-1:0]  pkt_bits;
    logic [NCOL-1:0]   bitmap;

    colscan_ctrl #(
        .NPKT (NPKT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_ready (grant_ready),
        .load        (load),
        .in_addr     (in_addr),
        .in_pkt      (in_pkt),
        .in_done     (in_done)
    );

    colscan_shift #(
        .NCOL   (NCOL),
        .PKT_W  (PKT_W),
        .ROW_AW (ROW_AW)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (in_pkt),
        .grant_row (grant_row),
        .col_req   (col_req),
        .row_addr  (row_addr),
        .pkt_bits  (pkt_bits),
        .bitmap    (bitmap)
    );

    always_comb begin
        bus_data = '0;
        if (in_addr) begin
            bus_data = BUS_W'(row_addr);
        end else if (in_pkt) begin
            bus_data = BUS_W'(pkt_bits);
        end
    end

    assign row_strobe = in_addr;
    assign pkt_strobe = in_pkt;
    assign row_done   = in_done;
    assign pix_ack    = in_done ? bitmap : '0;

endmodule

// File: rtl/colscan_checker.sv
module colscan_checker #(
    parameter int NCOL   = 16,
    parameter int PKT_W  = 4,
    parameter int ROW_AW = 5
) (
    input logic                                           clk,
    input logic                                           rst_n,
    input logic                                           grant_valid,
    input logic                                           grant_ready,
    input logic [((ROW_AW > PKT_W) ? ROW_AW : PKT_W)-1:0] bus_data,
    input logic                                           row_strobe,
    input logic                                           pkt_strobe,
    input logic                                           row_done,
    input logic [NCOL-1:0]                                pix_ack
);
    localparam int NPKT = NCOL / PKT_W;

    logic [15:0] pkt_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_seen <= '0;
        end else if (row_strobe) begin
            pkt_seen <= '0;
        end else if (pkt_strobe) begin
            pkt_seen <= pkt_seen + 16'd1;
        end
    end

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ready |-> !(row_strobe || pkt_strobe || row_done)); // R1
    AST_ADDR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_ready) |=> row_strobe); // R2
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_strobe || pkt_strobe) |-> (bus_data == '0)); // R2
    AST_PKT_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        row_strobe |=> pkt_strobe); // R3
    AST_ACK_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !row_done |-> (pix_ack == '0)); // R6
    AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> (pkt_seen == 16'(NPKT))); // R7
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_strobe, pkt_strobe, row_done})); // R7
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> grant_ready); // R8

endmodule

bind colscan_packetizer colscan_checker #(
    .NCOL   (NCOL),
    .PKT_W  (PKT_W),
    .ROW_AW (ROW_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .grant_ready (grant_ready),
    .bus_data    (bus_data),
    .row_strobe  (row_strobe),
    .pkt_strobe  (pkt_strobe),
    .row_done    (row_done),
    .pix_ack     (pix_ack)
);

// File: tb/test_colscan_packetizer.sv
`timescale 1ns/1ps
module test_colscan_packetizer;
    localparam int NCOL   = 16;
    localparam int PKT_W  = 4;
    localparam int ROW_AW = 5;
    localparam int NPKT   = NCOL / PKT_W;
    localparam int BUS_W  = (ROW_AW > PKT_W) ? ROW_AW : PKT_W;

    localparam int K_ADDR = 0;
    localparam int K_PKT  = 1;
    localparam int K_DONE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              grant_valid = 1'b0;
    logic [ROW_AW-1:0] grant_row = '0;
    logic [NCOL-1:0]   col_req = '0;
    logic              grant_ready;
    logic [BUS_W-1:0]  bus_data;
    logic              row_strobe;
    logic              pkt_strobe;
    logic              row_done;
    logic [NCOL-1:0]   pix_ack;

    typedef struct {
        int          kind;
        logic [31:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   in_row = 0;
    int   row_len = 0;
    int   pkt_cnt = 0;
    logic [NCOL-1:0] rebuilt = '0;

    always #4 clk = ~clk;

    colscan_packetizer #(
        .NCOL   (NCOL),
        .PKT_W  (PKT_W),
        .ROW_AW (ROW_AW)
    ) i_colscan_packetizer (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_row   (grant_row),
        .col_req     (col_req),
        .grant_ready (grant_ready),
        .bus_data    (bus_data),
        .row_strobe  (row_strobe),
        .pkt_strobe  (pkt_strobe),
        .row_done    (row_done),
        .pix_ack     (pix_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
        end
    endtask

    // Driver: offers a row, waits for acceptance, then scrambles col_req (R5)
    task automatic send_row(input logic [ROW_AW-1:0] r, input logic [NCOL-1:0] v);
        @(negedge clk);
        grant_valid = 1'b1;
        grant_row   = r;
        col_req     = v;
        while (!grant_ready) @(negedge clk);
        exp_q.push_back('{K_ADDR, 32'(r)});
        for (int k = 0; k < NPKT; k++) begin
            exp_q.push_back('{K_PKT, 32'(v[k*PKT_W +: PKT_W])});
        end
        exp_q.push_back('{K_DONE, 32'(v)});
        @(posedge clk);
        @(negedge clk);
        grant_valid = 1'b0;
        col_req     = ~v;
        grant_row   = ~r;
        check(grant_ready == 1'b0, "R1 ready low after accept", 32'(grant_ready), 32'd0);
    endtask

    // Monitor: pops the scoreboard on every output beat
    always @(negedge clk) begin
        if (rst_n) begin
            if (!row_done && pix_ack != '0)
                check(1'b0, "R6 ack outside done", 32'(pix_ack), 32'd0);
            if (row_strobe || pkt_strobe || row_done) begin
                int obs_kind;
                logic [31:0] obs;
                exp_t e;
                obs_kind = row_strobe ? K_ADDR : (pkt_strobe ? K_PKT : K_DONE);
                obs = row_done ? 32'(pix_ack) : 32'(bus_data);
                if (grant_ready)
                    check(1'b0, "R1 ready while beating", 32'd1, 32'd0);
                if (row_strobe) begin
                    in_row = 1; row_len = 0; pkt_cnt = 0; rebuilt = '0;
                end
                row_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected beat", 32'(obs_kind), 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    check(obs_kind == e.kind, "R7 beat kind order", 32'(obs_kind), 32'(e.kind));
                    if (obs_kind == e.kind) begin
                        if (obs_kind == K_ADDR)
                            check(obs == e.data, "R2 row address", obs, e.data);
                        else if (obs_kind == K_PKT)
                            check(obs == e.data, "R4 packet bits", obs, e.data);
                        else
                            check(obs == e.data, "R6 pix_ack", obs, e.data);
                    end
                end
                if (pkt_strobe) begin
                    if (pkt_cnt < NPKT) rebuilt[pkt_cnt*PKT_W +: PKT_W] = bus_data[PKT_W-1:0];
                    pkt_cnt++;
                end
                if (row_done) begin
                    check(rebuilt == pix_ack, "R3 reassembled bitmap", 32'(rebuilt), 32'(pix_ack));
                    check(pkt_cnt == NPKT, "R3 packet count", 32'(pkt_cnt), 32'(NPKT));
                    check(row_len == NPKT + 2, "R7 row duration", 32'(row_len), 32'(NPKT + 2));
                    in_row = 0;
                end
            end else if (in_row) begin
                check(1'b0, "R7 gap inside row", 32'(row_len), 32'(NPKT + 2));
                in_row = 0;
            end
        end
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(grant_ready == 1'b1, "R9 ready in reset", 32'(grant_ready), 32'd1);
        check({row_strobe, pkt_strobe, row_done} == 3'b000, "R9 strobes in reset",
              32'({row_strobe, pkt_strobe, row_done}), 32'd0);
        check(bus_data == '0 && pix_ack == '0, "R9 bus and ack in reset",
              32'(bus_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant_ready == 1'b1, "R9 ready after reset", 32'(grant_ready), 32'd1);

        send_row(5'd3,  16'h0000);   // R7 nothing fired
        send_row(5'd31, 16'hFFFF);   // R7 all fired
        send_row(5'd10, 16'hA5C3);   // R4 mixed pattern
        send_row(5'd1,  16'h0001);   // R4 lowest column only
        send_row(5'd17, 16'h8000);   // R4 highest column only
        // R8 back-to-back: the next offer is held while the row is busy
        send_row(5'd6,  16'h1234);
        send_row(5'd7,  16'hF00F);
        send_row(5'd8,  16'h0F0F);
        for (int i = 0; i < 20; i++) begin
            send_row(5'($urandom), 16'($urandom));
        end
        while (exp_q.size() != 0 || in_row) @(negedge clk);
        repeat (3) @(negedge clk);
        check(grant_ready == 1'b1, "R8 idle at end", 32'(grant_ready), 32'd1);
        check(bus_data == '0, "R2 bus quiet when idle", 32'(bus_data), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule